// File: doc/BRIEF.md
# Local-Oscillator Command Decoder

This block sits behind a CAN controller that has already removed bit timing, arbitration and CRC. Each received frame arrives on a one-cycle strobe as a 29-bit extended identifier, a byte count and up to eight payload bytes, left-aligned so that the first payload byte occupies `rx_data[63:56]`. The block decides whether the identifier belongs to this node and decodes the 18-bit offset inside the node's window into a control write or a monitor read. Malformed frames are rejected and counted.

Control writes drive two synthesizer channels and two IF selectors. Channel 0 is the upper oscillator and channel 1 is the lower one. Frequency and phase commands take effect on the next cycle. Offset-and-phase commands are held and applied on the first one-second tick that follows. Monitor reads, and the broadcast identifier, produce a reply on a valid/ready output. A read returns the last accepted payload of the matching control point, or that point's reset default. An activity pulse marks every frame received by the node and every reply sent.

Top module: `can_cmd_decoder`

## Requirements
- R1: A frame is for this node when `rx_id[28:18]` equals 0x200 + `node_sel`, so the window base is 0x0800_0000 + `node_sel`·0x4_0000 and the window spans offsets 0x0_0000 to 0x3_FFFF. A frame with any other nonzero identifier changes no output and no counter.
- R2: Offset 0x103 takes exactly 4 bytes. Byte 1 sets the IF1 frequency (1 = 4 GHz, 0 = 2 GHz), byte 2 sets the IF1 polarization (1 = horizontal, 0 = vertical), byte 3 sets the IF2 frequency and byte 4 sets the IF2 polarization. In `if_freq4g` and `if_polh`, bit 0 is IF1 and bit 1 is IF2. After reset both outputs are 2'b11.
- R3: Offset 0x101 takes exactly 7 bytes. Byte 1 is the target (0 = upper/channel 0, 1 = lower/channel 1), bytes 2–5 are a 32-bit frequency word and bytes 6–7 are a 16-bit phase. On the next cycle the target's `lo_freq` and `lo_phase` fields hold these values and its `lo_upd` bit pulses for one cycle. Channel 0 sits in `lo_freq[31:0]` and `lo_phase[15:0]`; channel 1 sits in `lo_freq[63:32]` and `lo_phase[31:16]`.
- R4: Offset 0x102 takes exactly 3 bytes: byte 1 is the target and bytes 2–3 are the phase. On the next cycle the target's phase is updated and its `lo_upd` bit pulses. Its frequency field is left unchanged.
- R5: Offset 0x109 (upper) and offset 0x108 (lower) each take exactly 6 bytes: a 32-bit signed offset followed by a 16-bit phase. The values are staged and do not change any output until the first `sec_tick`. The cycle after that tick the channel takes the staged values and its `lo_upd` bit pulses. A later tick with nothing staged does nothing.
- R6: Offset 0x100 takes exactly 8 bytes. Bytes 1–2 are the upper signed 16-bit offset, bytes 3–4 the upper phase, bytes 5–6 the lower signed offset and bytes 7–8 the lower phase. Both channels are staged as in R5, with each offset sign-extended to 32 bits.
- R7: A zero-length frame at offsets 0x200–0x205, 0x208 or 0x209 requests a reply with the same identifier. The reply carries the last accepted payload of control point 0x100, 0x101 with target 1, 0x101 with target 0, 0x102 with target 1, 0x102 with target 0, 0x103, 0x108 or 0x109 respectively. Its length is 8, 7, 7, 3, 3, 4, 6 or 6. Before any write the reply data is zero, except at 0x205, which returns 0x01010101 in the top four bytes.
- R8: A frame with identifier 0 requests a reply whose identifier is the node base address and whose length is 0.
- R9: At most one reply is outstanding. `tx_valid` stays high and `tx_id`, `tx_len` and `tx_data` stay stable until a cycle with `tx_ready` high. A read or broadcast that arrives while a reply is pending is dropped and counted as an error.
- R10: An in-window frame is dropped without any state change and increments `err_cnt` in these cases: its byte count differs from the length of its offset, its offset is undefined, or a target or IF byte is greater than 1. `err_cnt` saturates at 255.
- R11: `activity` is high for one cycle after a cycle in which an in-window or broadcast frame is received, or in which a reply is handed over (`tx_valid` and `tx_ready` both high).
- R12: Offset 0x1F0 with 1 byte clears both channels and any staged values, and pulses both `lo_upd` bits on the next cycle.
- R13: Offset 0x1FF with 1 byte returns every stored control point and the IF selectors to their reset defaults and clears both channels and staged values. It does not pulse `lo_upd` and does not change `err_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_sel | input | 8 | Node number setting the address window |
| sec_tick | input | 1 | One-cycle pulse of the one-second timing event |
| rx_valid | input | 1 | A received frame is presented this cycle |
| rx_id | input | 29 | Extended identifier of the received frame |
| rx_len | input | 4 | Payload byte count |
| rx_data | input | 64 | Payload, first byte in bits 63:56 |
| tx_ready | input | 1 | Reply accepted by the transmitter |
| tx_valid | output | 1 | Reply pending |
| tx_id | output | 29 | Reply identifier |
| tx_len | output | 4 | Reply byte count |
| tx_data | output | 64 | Reply payload, first byte in bits 63:56 |
| if_freq4g | output | 2 | IF frequency select per IF, 1 = 4 GHz |
| if_polh | output | 2 | IF polarization select per IF, 1 = horizontal |
| lo_upd | output | 2 | Per-channel update pulse |
| lo_freq | output | 64 | Per-channel applied frequency word or offset |
| lo_phase | output | 32 | Per-channel applied phase |
| activity | output | 1 | Frame activity pulse |
| err_cnt | output | 8 | Saturating count of dropped frames |

## Verification
Every result of a received frame is registered once, so the IF selectors, immediate channel updates, staged values, error count, activity pulse and reply fields all appear in the cycle after the accepting edge. The bench drives each frame for exactly one cycle starting at a falling edge and samples at the next falling edge. Staged commands are checked twice: over several idle cycles after the frame, where nothing may change, and then at the falling edge after the `sec_tick` cycle. Reply contents are read while `tx_valid` is held. The handshake is then completed, and the activity pulse is checked one cycle later.

// File: rtl/can_cmd_pkg.sv
package can_cmd_pkg;
  localparam int ID_W   = 29;
  localparam int LEN_W  = 4;
  localparam int DATA_W = 64;
  localparam int N_LO   = 2;
  localparam int N_SLOT = 8;
  localparam int SLOT_W = $clog2(N_SLOT);
  localparam int IF_SLOT = 5;

  typedef enum logic [3:0] {
    OP_BAD, OP_DUAL, OP_FREQ, OP_PHASE, OP_IFSEL,
    OP_LO_LOW, OP_LO_UP, OP_INIT, OP_RST, OP_READ
  } op_e;

  function automatic logic [15:0] be16(input logic [DATA_W-1:0] d, input int k);
    return d[DATA_W-1-8*k -: 16];
  endfunction

  function automatic logic [31:0] be32(input logic [DATA_W-1:0] d, input int k);
    return d[DATA_W-1-8*k -: 32];
  endfunction

  function automatic logic [31:0] sext16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [LEN_W-1:0] slot_len(input logic [SLOT_W-1:0] s);
    case (s)
      3'd0:       return 4'd8;
      3'd1, 3'd2: return 4'd7;
      3'd3, 3'd4: return 4'd3;
      3'd5:       return 4'd4;
      default:    return 4'd6;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] slot_default(input int s);
    return (s == IF_SLOT) ? 64'h0101_0101_0000_0000 : '0;
  endfunction
endpackage

// File: rtl/can_cmd_decode.sv
module can_cmd_decode
  import can_cmd_pkg::*;
#(
  parameter logic [10:0] WIN_HI = 11'h200
) (
  input  logic [ID_W-1:0]   id,
  input  logic [LEN_W-1:0]  len,
  input  logic [31:0]       head,
  input  logic [7:0]        node_sel,
  output logic              hit,
  output logic              bcast,
  output op_e               op,
  output logic [SLOT_W-1:0] slot
);
  logic [7:0] b0, b1, b2, b3;
  logic       tgt_ok, if_ok;

  assign b0 = head[31:24];
  assign b1 = head[23:16];
  assign b2 = head[15:8];
  assign b3 = head[7:0];
  assign tgt_ok = (b0 <= 8'd1);
  assign if_ok  = tgt_ok && (b1 <= 8'd1) && (b2 <= 8'd1) && (b3 <= 8'd1);

  assign hit   = (id[ID_W-1:18] == (WIN_HI + {3'b000, node_sel}));
  assign bcast = (id == '0);

  always_comb begin
    op   = OP_BAD;
    slot = '0;
    case (id[17:0])
      18'h00100: if (len == 4'd8) begin op = OP_DUAL; slot = 3'd0; end
      18'h00101: if (len == 4'd7 && tgt_ok) begin op = OP_FREQ;  slot = b0[0] ? 3'd1 : 3'd2; end
      18'h00102: if (len == 4'd3 && tgt_ok) begin op = OP_PHASE; slot = b0[0] ? 3'd3 : 3'd4; end
      18'h00103: if (len == 4'd4 && if_ok) begin op = OP_IFSEL; slot = 3'd5; end
      18'h00108: if (len == 4'd6) begin op = OP_LO_LOW; slot = 3'd6; end
      18'h00109: if (len == 4'd6) begin op = OP_LO_UP;  slot = 3'd7; end
      18'h001F0: if (len == 4'd1) op = OP_INIT;
      18'h001FF: if (len == 4'd1) op = OP_RST;
      18'h00200, 18'h00201, 18'h00202, 18'h00203, 18'h00204, 18'h00205:
        if (len == 4'd0) begin op = OP_READ; slot = id[2:0]; end
      18'h00208: if (len == 4'd0) begin op = OP_READ; slot = 3'd6; end
      18'h00209: if (len == 4'd0) begin op = OP_READ; slot = 3'd7; end
      default: op = OP_BAD;
    endcase
  end
endmodule

// File: rtl/can_cmd_slots.sv
module can_cmd_slots
  import can_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              restore,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        if_freq4g,
  output logic [1:0]        if_polh
);
  logic [DATA_W-1:0] mem [N_SLOT];

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        mem[g] <= slot_default(g);
      else if (restore)                  mem[g] <= slot_default(g);
      else if (wr_en && wr_slot == g[SLOT_W-1:0]) mem[g] <= wr_data;
    end
  end

  assign rd_data   = mem[rd_slot];
  assign if_freq4g = {mem[IF_SLOT][40], mem[IF_SLOT][56]};
  assign if_polh   = {mem[IF_SLOT][32], mem[IF_SLOT][48]};
endmodule

// File: rtl/can_lo_chan.sv
module can_lo_chan (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sec_tick,
  input  logic        clear,
  input  logic        clear_pulse,
  input  logic        stage_en,
  input  logic [31:0] stage_off,
  input  logic [15:0] stage_ph,
  input  logic        imm_f_en,
  input  logic [31:0] imm_f,
  input  logic        imm_p_en,
  input  logic [15:0] imm_p,
  output logic [31:0] freq,
  output logic [15:0] phase,
  output logic        upd
);
  logic        pend;
  logic [31:0] stg_off;
  logic [15:0] stg_ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq <= '0; phase <= '0; upd <= 1'b0;
      pend <= 1'b0; stg_off <= '0; stg_ph <= '0;
    end else begin
      upd <= 1'b0;
      if (clear) begin
        freq <= '0; phase <= '0; pend <= 1'b0;
        stg_off <= '0; stg_ph <= '0;
        upd <= clear_pulse;
      end else begin
        if (sec_tick && pend) begin
          freq <= stg_off; phase <= stg_ph; pend <= 1'b0; upd <= 1'b1;
        end
        if (stage_en) begin
          stg_off <= stage_off; stg_ph <= stage_ph; pend <= 1'b1;
        end
        if (imm_f_en) begin freq  <= imm_f; upd <= 1'b1; end
        if (imm_p_en) begin phase <= imm_p; upd <= 1'b1; end
      end
    end
  end
endmodule

// File: rtl/can_cmd_decoder.sv
module can_cmd_decoder
  import can_cmd_pkg::*;
#(
  parameter logic [10:0] WIN_HI = 11'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        node_sel,
  input  logic              sec_tick,
  input  logic              rx_valid,
  input  logic [ID_W-1:0]   rx_id,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [ID_W-1:0]   tx_id,
  output logic [LEN_W-1:0]  tx_len,
  output logic [DATA_W-1:0] tx_data,
  output logic [1:0]        if_freq4g,
  output logic [1:0]        if_polh,
  output logic [N_LO-1:0]   lo_upd,
  output logic [32*N_LO-1:0] lo_freq,
  output logic [16*N_LO-1:0] lo_phase,
  output logic              activity,
  output logic [7:0]        err_cnt
);
  logic              hit, bcast;
  op_e               op;
  logic [SLOT_W-1:0] slot;
  logic [DATA_W-1:0] rd_data;

  can_cmd_decode #(.WIN_HI(WIN_HI)) u_dec (
    .id(rx_id), .len(rx_len), .head(rx_data[63:32]), .node_sel(node_sel),
    .hit(hit), .bcast(bcast), .op(op), .slot(slot)
  );

  // named internal events
  logic acc, wr_store, req, busy_drop, bad_frame, handover, tgt_low;
  assign acc       = rx_valid && hit;
  assign wr_store  = acc && (op inside {OP_DUAL, OP_FREQ, OP_PHASE, OP_IFSEL, OP_LO_LOW, OP_LO_UP});
  assign req       = rx_valid && (bcast || (hit && op == OP_READ));
  assign busy_drop = req && tx_valid;
  assign bad_frame = (acc && op == OP_BAD) || busy_drop;
  assign handover  = tx_valid && tx_ready;
  assign tgt_low   = rx_data[56];

  can_cmd_slots u_slots (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_store), .wr_slot(slot), .wr_data(rx_data),
    .restore(acc && op == OP_RST), .rd_slot(slot), .rd_data(rd_data),
    .if_freq4g(if_freq4g), .if_polh(if_polh)
  );

  for (genvar g = 0; g < N_LO; g++) begin : g_lo
    logic        st_en, f_en, p_en;
    logic [31:0] st_off;
    logic [15:0] st_ph, p_val;
    localparam bit LOWER = (g == 1);
    assign st_en  = acc && (op == OP_DUAL || op == (LOWER ? OP_LO_LOW : OP_LO_UP));
    assign st_off = (op == OP_DUAL) ? sext16(be16(rx_data, LOWER ? 4 : 0)) : be32(rx_data, 0);
    assign st_ph  = (op == OP_DUAL) ? be16(rx_data, LOWER ? 6 : 2) : be16(rx_data, 4);
    assign f_en   = acc && op == OP_FREQ && (tgt_low == LOWER);
    assign p_en   = acc && (op == OP_FREQ || op == OP_PHASE) && (tgt_low == LOWER);
    assign p_val  = (op == OP_FREQ) ? be16(rx_data, 5) : be16(rx_data, 1);

    can_lo_chan u_ch (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
      .clear(acc && (op == OP_INIT || op == OP_RST)), .clear_pulse(op == OP_INIT),
      .stage_en(st_en), .stage_off(st_off), .stage_ph(st_ph),
      .imm_f_en(f_en), .imm_f(be32(rx_data, 1)), .imm_p_en(p_en), .imm_p(p_val),
      .freq(lo_freq[32*g +: 32]), .phase(lo_phase[16*g +: 16]), .upd(lo_upd[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0; tx_id <= '0; tx_len <= '0; tx_data <= '0;
      activity <= 1'b0; err_cnt <= '0;
    end else begin
      activity <= (rx_valid && (hit || bcast)) || handover;
      if (bad_frame && err_cnt != 8'hFF) err_cnt <= err_cnt + 8'd1;
      if (handover) tx_valid <= 1'b0;
      if (req && !tx_valid) begin
        tx_valid <= 1'b1;
        tx_id    <= bcast ? {WIN_HI + {3'b000, node_sel}, 18'h0} : rx_id;
        tx_len   <= bcast ? '0 : slot_len(slot);
        tx_data  <= bcast ? '0 : rd_data;
      end
    end
  end
endmodule

// File: rtl/can_cmd_checker.sv
module can_cmd_checker
  import can_cmd_pkg::*;
#(
  parameter logic [10:0] WIN_HI = 11'h200
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        node_sel,
  input logic              sec_tick,
  input logic              rx_valid,
  input logic [ID_W-1:0]   rx_id,
  input logic              tx_ready,
  input logic              tx_valid,
  input logic [ID_W-1:0]   tx_id,
  input logic [LEN_W-1:0]  tx_len,
  input logic [DATA_W-1:0] tx_data,
  input logic [1:0]        if_freq4g,
  input logic [1:0]        if_polh,
  input logic [N_LO-1:0]   lo_upd,
  input logic              activity,
  input logic [7:0]        err_cnt
);
  logic foreign;
  assign foreign = rx_valid && rx_id != '0 &&
                   rx_id[ID_W-1:18] != (WIN_HI + {3'b000, node_sel});

  a_r1_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    foreign && !sec_tick |=> $stable(if_freq4g) && $stable(if_polh) &&
                             $stable(err_cnt) && lo_upd == '0);

  a_r9_reply_held: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_id) && $stable(tx_len) && $stable(tx_data));

  a_r10_err_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt == 8'hFF |=> err_cnt == 8'hFF);

  a_r10_err_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt != 8'hFF |=> (err_cnt == $past(err_cnt) || err_cnt == $past(err_cnt) + 8'd1));

  a_r11_bcast_activity: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_id == '0 |=> activity);

  a_r5_upd_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    lo_upd != '0 |-> $past(rx_valid || sec_tick));
endmodule

bind can_cmd_decoder can_cmd_checker #(.WIN_HI(WIN_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .node_sel(node_sel), .sec_tick(sec_tick),
  .rx_valid(rx_valid), .rx_id(rx_id), .tx_ready(tx_ready), .tx_valid(tx_valid),
  .tx_id(tx_id), .tx_len(tx_len), .tx_data(tx_data), .if_freq4g(if_freq4g),
  .if_polh(if_polh), .lo_upd(lo_upd), .activity(activity), .err_cnt(err_cnt)
);

// File: tb/sim_can_cmd_decoder.sv
module sim_can_cmd_decoder;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  node_sel = 8'd5;
  logic        sec_tick = 1'b0, rx_valid = 1'b0, tx_ready = 1'b0;
  logic [28:0] rx_id = '0;
  logic [3:0]  rx_len = '0;
  logic [63:0] rx_data = '0;
  logic        tx_valid, activity;
  logic [28:0] tx_id;
  logic [3:0]  tx_len;
  logic [63:0] tx_data, lo_freq;
  logic [1:0]  if_freq4g, if_polh, lo_upd;
  logic [31:0] lo_phase;
  logic [7:0]  err_cnt;

  int checks = 0, failures = 0, exp_err = 0;

  can_cmd_decoder u0 (.*);

  always #5 clk = ~clk;

  function automatic logic [28:0] base_of(input int s);
    return 29'h0800_0000 + 29'(s) * 29'h4_0000;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [28:0] id, input logic [3:0] len, input logic [63:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_id = id; rx_len = len; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic bump_err();
    if (exp_err < 255) exp_err++;
  endtask

  task automatic release_reply();
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    chk("R11 activity after handover", 64'(activity), 64'd1);
    chk("R9 reply cleared", 64'(tx_valid), 64'd0);
  endtask

  task automatic read_check(input logic [17:0] off, input logic [3:0] elen, input logic [63:0] edata);
    send(base_of(node_sel) + 29'(off), 4'd0, 64'd0);
    chk("R7 reply valid", 64'(tx_valid), 64'd1);
    chk("R7 reply id", 64'(tx_id), 64'(base_of(node_sel) + 29'(off)));
    chk("R7 reply len", 64'(tx_len), 64'(elen));
    chk("R7 reply data", tx_data, edata);
    release_reply();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [28:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset IF freq", 64'(if_freq4g), 64'h3);
    chk("R2 reset IF pol", 64'(if_polh), 64'h3);
    chk("R9 reset tx_valid", 64'(tx_valid), 64'd0);
    chk("R10 reset err_cnt", 64'(err_cnt), 64'd0);
    chk("R3 reset lo_upd", 64'(lo_upd), 64'd0);

    // R1: window sweep across node numbers
    for (int s = 0; s < 256; s += 15) begin
      node_sel = 8'(s);
      b = base_of(s);
      send(b + 29'h103, 4'd4, {8'd0, 7'd0, s[0], 8'd1, 7'd0, s[1], 32'd0});
      chk("R1 in-window IF freq", 64'(if_freq4g), 64'h2);
      chk("R1 in-window IF pol", 64'(if_polh), 64'({s[1], s[0]}));
      send((s < 255 ? b + 29'h4_0000 : b - 29'h4_0000) + 29'h103, 4'd4, 64'h0101_0101_0000_0000);
      chk("R1 foreign frame IF", 64'({if_freq4g, if_polh}), 64'({2'b10, s[1], s[0]}));
      chk("R1 foreign frame activity", 64'(activity), 64'd0);
      send(b + 29'h3_FFFF, 4'd0, 64'd0);
      bump_err();
      chk("R1 window top offset counted", 64'(err_cnt), 64'(exp_err));
    end
    node_sel = 8'd5;
    b = base_of(5);

    // R2: every IF pattern, echoed by the monitor point
    for (int p = 0; p < 16; p++) begin
      send(b + 29'h103, 4'd4, {7'd0, p[0], 7'd0, p[1], 7'd0, p[2], 7'd0, p[3], 32'd0});
      chk("R2 IF freq", 64'(if_freq4g), 64'({p[2], p[0]}));
      chk("R2 IF pol", 64'(if_polh), 64'({p[3], p[1]}));
      chk("R11 activity after rx", 64'(activity), 64'd1);
    end
    read_check(18'h205, 4'd4, 64'h0101_0101_0000_0000);
    // R10: IF byte of 2, wrong length, undefined offset, bad target
    send(b + 29'h103, 4'd4, 64'h0102_0101_0000_0000); bump_err();
    chk("R10 bad IF byte dropped", 64'({if_freq4g, if_polh}), 64'hF);
    chk("R10 bad IF byte counted", 64'(err_cnt), 64'(exp_err));
    send(b + 29'h103, 4'd3, 64'h0000_0000_0000_0000); bump_err();
    chk("R10 wrong length dropped", 64'({if_freq4g, if_polh}), 64'hF);
    chk("R10 wrong length counted", 64'(err_cnt), 64'(exp_err));
    send(b + 29'h104, 4'd4, 64'd0); bump_err();
    chk("R10 undefined offset counted", 64'(err_cnt), 64'(exp_err));
    send(b + 29'h101, 4'd7, 64'h0211_2233_4455_6600); bump_err();
    chk("R10 bad target no update", 64'(lo_upd), 64'd0);
    chk("R10 bad target counted", 64'(err_cnt), 64'(exp_err));

    // R3: immediate frequency, lower then upper
    send(b + 29'h101, 4'd7, 64'h0112_3456_7801_2300);
    chk("R3 lower upd", 64'(lo_upd), 64'h2);
    chk("R3 lower freq", 64'(lo_freq[63:32]), 64'h1234_5678);
    chk("R3 lower phase", 64'(lo_phase[31:16]), 64'h0123);
    chk("R3 upper untouched", 64'(lo_freq[31:0]), 64'd0);
    send(b + 29'h101, 4'd7, 64'h00CA_FE00_0103_E700);
    chk("R3 upper upd", 64'(lo_upd), 64'h1);
    chk("R3 upper freq", 64'(lo_freq[31:0]), 64'hCAFE_0001);
    chk("R3 upper phase", 64'(lo_phase[15:0]), 64'h03E7);
    @(negedge clk);
    chk("R3 pulse one cycle", 64'(lo_upd), 64'd0);
    // R4: phase only
    send(b + 29'h102, 4'd3, 64'h0100_2A00_0000_0000);
    chk("R4 upd", 64'(lo_upd), 64'h2);
    chk("R4 phase", 64'(lo_phase[31:16]), 64'h002A);
    chk("R4 freq kept", 64'(lo_freq[63:32]), 64'h1234_5678);
    // R7: echoes and defaults
    read_check(18'h201, 4'd7, 64'h0112_3456_7801_2300);
    read_check(18'h202, 4'd7, 64'h00CA_FE00_0103_E700);
    read_check(18'h203, 4'd3, 64'h0100_2A00_0000_0000);
    read_check(18'h204, 4'd3, 64'd0);
    read_check(18'h200, 4'd8, 64'd0);

    // R5: staged per-LO command
    send(b + 29'h109, 4'd6, 64'h8000_0001_01F4_0000);
    chk("R5 no immediate upd", 64'(lo_upd), 64'd0);
    repeat (3) @(negedge clk);
    chk("R5 held before tick", 64'(lo_freq[31:0]), 64'hCAFE_0001);
    tick();
    chk("R5 tick upd", 64'(lo_upd), 64'h1);
    chk("R5 tick freq", 64'(lo_freq[31:0]), 64'h8000_0001);
    chk("R5 tick phase", 64'(lo_phase[15:0]), 64'd500);
    tick();
    chk("R5 empty tick", 64'(lo_upd), 64'd0);
    send(b + 29'h108, 4'd6, 64'h0000_0007_0009_0000);
    tick();
    chk("R5 lower tick upd", 64'(lo_upd), 64'h2);
    chk("R5 lower freq", 64'(lo_freq[63:32]), 64'h7);
    read_check(18'h209, 4'd6, 64'h8000_0001_01F4_0000);

    // R6: dual staged with sign extension
    send(b + 29'h100, 4'd8, 64'hFF38_000A_0064_03E7);
    chk("R6 no immediate upd", 64'(lo_upd), 64'd0);
    tick();
    chk("R6 both upd", 64'(lo_upd), 64'h3);
    chk("R6 upper offset", 64'(lo_freq[31:0]), 64'hFFFF_FF38);
    chk("R6 lower offset", 64'(lo_freq[63:32]), 64'h64);
    chk("R6 phases", 64'(lo_phase), 64'h03E7_000A);

    // R8 and R9: broadcast reply, then a request while busy
    send(29'd0, 4'd0, 64'd0);
    chk("R11 activity on broadcast", 64'(activity), 64'd1);
    chk("R8 reply valid", 64'(tx_valid), 64'd1);
    chk("R8 reply id", 64'(tx_id), 64'(b));
    chk("R8 reply len", 64'(tx_len), 64'd0);
    send(b + 29'h205, 4'd0, 64'd0); bump_err();
    chk("R9 busy request dropped", 64'(tx_id), 64'(b));
    chk("R9 busy request counted", 64'(err_cnt), 64'(exp_err));
    release_reply();

    // R12: init
    send(b + 29'h1F0, 4'd1, 64'd0);
    chk("R12 both upd", 64'(lo_upd), 64'h3);
    chk("R12 freq cleared", lo_freq, 64'd0);
    // R13: processor reset
    send(b + 29'h103, 4'd4, 64'd0);
    send(b + 29'h109, 4'd6, 64'h0000_0005_0000_0000);
    send(b + 29'h1FF, 4'd1, 64'd0);
    chk("R13 no upd", 64'(lo_upd), 64'd0);
    chk("R13 IF default", 64'({if_freq4g, if_polh}), 64'hF);
    chk("R13 err kept", 64'(err_cnt), 64'(exp_err));
    tick();
    chk("R13 staged cleared", 64'(lo_upd), 64'd0);
    read_check(18'h201, 4'd7, 64'd0);
    read_check(18'h205, 4'd4, 64'h0101_0101_0000_0000);

    // R10: saturation
    for (int i = 0; i < 260; i++) begin
      send(b + 29'h1F0, 4'd2, 64'd0); bump_err();
    end
    chk("R10 err saturates", 64'(err_cnt), 64'd255);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule